// File: doc/BRIEF.md
# Microcode Field Decoder Datapath

This block is the register-transfer slice of a microprogrammed control unit. Each clock cycle it takes three 3-bit micro-operation fields (`mop_a`, `mop_b`, `mop_c`) from the current microinstruction. Each field goes through its own 3-to-8 one-hot decoder. The decoded lines select a transfer into one of two architectural registers: a 16-bit accumulator or a 12-bit address register.

The operands come from a 16-bit data register and a 12-bit program counter. Both are loaded through their own load ports. A small ALU provides addition and bitwise AND. The control store and next-address sequencing are outside this block. So are the condition, branch and address fields of the microinstruction.

The select logic is written as two named source selectors, one for each destination register:

| Selector | Values |
|---|---|
| Accumulator source | `ACC_HOLD`, `ACC_SUM`, `ACC_AND` |
| Address-register source | `ADR_HOLD`, `ADR_FROM_DATA`, `ADR_FROM_PC` |

In each cycle, each selector takes exactly one value, chosen from the decoded fields, and the register update follows on the next rising edge. No other state or transition exists.

Top module: `ucode_field_dp`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, address register, data register and program counter to zero on the rising clock edge.
- R2: `mop_a` = 1 sets the accumulator to (accumulator + data register) modulo 2^16 at the next rising edge.
- R3: `mop_b` = 3 sets the accumulator to accumulator AND data register at the next rising edge, unless R8 applies.
- R4: `mop_a` = 5 loads bits [11:0] of the data register into the address register at the next rising edge; bits [15:12] are dropped.
- R5: `mop_a` = 6 copies the program counter into the address register at the next rising edge.
- R6: The data register and program counter load on the rising edge when their load enables are high. A micro-operation in the same cycle uses the value these registers held before that edge.
- R7: The accumulator and address register are left unchanged by every other combination of field codes:
  - code 0 in any field;
  - `mop_a` codes 2, 3, 4 and 7;
  - every `mop_b` code other than 3;
  - every `mop_c` code.
- R8: When `mop_a` = 1 and `mop_b` = 3 arrive together, the addition from `mop_a` has priority and the AND is discarded.
- R9: When `mop_a` selects 5 or 6 and `mop_b` = 3 in the same cycle, both transfers take place: the address register is loaded as in R4 or R5, and the accumulator is loaded as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mop_a | input | 3 | First micro-operation field |
| mop_b | input | 3 | Second micro-operation field |
| mop_c | input | 3 | Third micro-operation field (no transfer assigned) |
| data_ld | input | 1 | Load enable for the data register |
| data_in | input | 16 | Value written to the data register |
| pc_ld | input | 1 | Load enable for the program counter |
| pc_in | input | 12 | Value written to the program counter |
| acc_out | output | 16 | Accumulator contents |
| adr_out | output | 12 | Address register contents |

## Verification
Every result is due exactly one rising edge after its fields are presented, since each path runs from decoder to selector to a single register. The exception is a data or program-counter load, which becomes visible at the outputs only through a later transfer, one edge after that transfer.

The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next edge. It advances a behavioural reference model at that same edge and compares both outputs in every cycle. Hidden data-register bits are brought out through a code-5 transfer into the address register.

// File: rtl/ucode_dp_pkg.sv
package ucode_dp_pkg;
    localparam int unsigned FIELD_W = 3;
    localparam int unsigned ACC_W   = 16;
    localparam int unsigned ADR_W   = 12;

    localparam logic [FIELD_W-1:0] OPA_ADD      = 3'd1;
    localparam logic [FIELD_W-1:0] OPA_DATA2ADR = 3'd5;
    localparam logic [FIELD_W-1:0] OPA_PC2ADR   = 3'd6;
    localparam logic [FIELD_W-1:0] OPB_AND      = 3'd3;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_SUM,
        ACC_AND
    } acc_src_e;

    typedef enum logic [1:0] {
        ADR_HOLD,
        ADR_FROM_DATA,
        ADR_FROM_PC
    } adr_src_e;
endpackage

// File: rtl/ucode_field_decoder.sv
module ucode_field_decoder #(
    parameter int unsigned CODE_W = 3,
    localparam int unsigned LINES = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  lines
);
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lines[i] = (code == CODE_W'(i));
        end
    end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    output logic [W-1:0] sum,
    output logic [W-1:0] conj
);
    always_comb begin
        sum  = opnd_x + opnd_y;
        conj = opnd_x & opnd_y;
    end
endmodule

// File: rtl/ucode_field_dp.sv
module ucode_field_dp
    import ucode_dp_pkg::*;
#(
    parameter int unsigned FW = FIELD_W,
    parameter int unsigned AW = ACC_W,
    parameter int unsigned RW = ADR_W,
    localparam int unsigned NL = 1 << FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] mop_a,
    input  logic [FW-1:0] mop_b,
    input  logic [FW-1:0] mop_c,
    input  logic          data_ld,
    input  logic [AW-1:0] data_in,
    input  logic          pc_ld,
    input  logic [RW-1:0] pc_in,
    output logic [AW-1:0] acc_out,
    output logic [RW-1:0] adr_out
);
    logic [NL-1:0] a_lines, b_lines, c_lines;
    logic [AW-1:0] acc_q, data_q, alu_sum, alu_conj;
    logic [RW-1:0] adr_q, pc_q;
    logic          c_decoded;
    acc_src_e      acc_src;
    adr_src_e      adr_src;

    ucode_field_decoder #(.CODE_W(FW)) u_dec_a (.code(mop_a), .lines(a_lines));
    ucode_field_decoder #(.CODE_W(FW)) u_dec_b (.code(mop_b), .lines(b_lines));
    ucode_field_decoder #(.CODE_W(FW)) u_dec_c (.code(mop_c), .lines(c_lines));

    ucode_alu #(.W(AW)) u_alu (
        .opnd_x(acc_q),
        .opnd_y(data_q),
        .sum   (alu_sum),
        .conj  (alu_conj)
    );

    // Third field: decoded for a well-formed code, but no line drives a transfer.
    assign c_decoded = |c_lines;

    // Accumulator source; the first field wins over the second.
    always_comb begin
        if (c_decoded && a_lines[OPA_ADD])
            acc_src = ACC_SUM;
        else if (c_decoded && b_lines[OPB_AND])
            acc_src = ACC_AND;
        else
            acc_src = ACC_HOLD;
    end

    // Address-register source; only the first field addresses it.
    always_comb begin
        if (c_decoded && a_lines[OPA_DATA2ADR])
            adr_src = ADR_FROM_DATA;
        else if (c_decoded && a_lines[OPA_PC2ADR])
            adr_src = ADR_FROM_PC;
        else
            adr_src = ADR_HOLD;
    end

    // Register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            adr_q  <= '0;
            data_q <= '0;
            pc_q   <= '0;
        end else begin
            unique case (acc_src)
                ACC_SUM:  acc_q <= alu_sum;
                ACC_AND:  acc_q <= alu_conj;
                default:  acc_q <= acc_q;
            endcase
            unique case (adr_src)
                ADR_FROM_DATA: adr_q <= data_q[RW-1:0];
                ADR_FROM_PC:   adr_q <= pc_q;
                default:       adr_q <= adr_q;
            endcase
            if (data_ld) data_q <= data_in;
            if (pc_ld)   pc_q   <= pc_in;
        end
    end

    // Output process.
    always_comb begin
        acc_out = acc_q;
        adr_out = adr_q;
    end
endmodule

// File: rtl/ucode_field_dp_chk.sv
module ucode_field_dp_chk #(
    parameter int unsigned FW = 3,
    parameter int unsigned AW = 16,
    parameter int unsigned RW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [FW-1:0] mop_a,
    input logic [FW-1:0] mop_b,
    input logic [AW-1:0] acc_out,
    input logic [RW-1:0] adr_out,
    input logic [AW-1:0] data_q,
    input logic [RW-1:0] pc_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && adr_out == '0 && data_q == '0 && pc_q == '0));

    // R2
    acc_add_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a == 3'd1) |=> (acc_out == AW'($past(acc_out) + $past(data_q))));

    // R3
    acc_and_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a != 3'd1 && mop_b == 3'd3) |=> (acc_out == ($past(acc_out) & $past(data_q))));

    // R4
    adr_from_data_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a == 3'd5) |=> (adr_out == $past(data_q[RW-1:0])));

    // R5
    adr_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a == 3'd6) |=> (adr_out == $past(pc_q)));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a != 3'd1 && mop_b != 3'd3) |=> $stable(acc_out));

    // R7
    adr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mop_a != 3'd5 && mop_a != 3'd6) |=> $stable(adr_out));
endmodule

bind ucode_field_dp ucode_field_dp_chk #(.FW(FW), .AW(AW), .RW(RW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mop_a  (mop_a),
    .mop_b  (mop_b),
    .acc_out(acc_out),
    .adr_out(adr_out),
    .data_q (data_q),
    .pc_q   (pc_q)
);

// File: tb/sim_ucode_field_dp.sv
`timescale 1ns/1ps
module sim_ucode_field_dp;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mop_a, mop_b, mop_c;
    logic        data_ld, pc_ld;
    logic [15:0] data_in;
    logic [11:0] pc_in;
    logic [15:0] acc_out;
    logic [11:0] adr_out;

    int errors = 0;
    int checks = 0;

    // reference state
    int m_acc, m_adr, m_data, m_pc;

    always #4 clk = ~clk;

    ucode_field_dp u0 (
        .clk(clk), .rst(rst),
        .mop_a(mop_a), .mop_b(mop_b), .mop_c(mop_c),
        .data_ld(data_ld), .data_in(data_in),
        .pc_ld(pc_ld), .pc_in(pc_in),
        .acc_out(acc_out), .adr_out(adr_out)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    function automatic string acc_tag(int a, int b);
        if (a == 1 && b == 3) return "R8";
        if (a == 1) return "R2";
        if (b == 3) return "R3";
        return "R7";
    endfunction

    function automatic string adr_tag(int a, int b);
        if ((a == 5 || a == 6) && b == 3) return "R9";
        if (a == 5) return "R4";
        if (a == 6) return "R5";
        return "R7";
    endfunction

    // one cycle: drive, clock, advance model, compare
    task automatic step(int a, int b, int c, bit dl, int dv, bit pl, int pv);
        int na, nr;
        mop_a = 3'(a); mop_b = 3'(b); mop_c = 3'(c);
        data_ld = dl; data_in = 16'(dv); pc_ld = pl; pc_in = 12'(pv);
        na = m_acc; nr = m_adr;
        if (a == 1)      na = (m_acc + m_data) & 16'hFFFF;
        else if (b == 3) na = m_acc & m_data;
        if (a == 5)      nr = m_data & 12'hFFF;
        else if (a == 6) nr = m_pc;
        @(posedge clk); #1;
        m_acc = na; m_adr = nr;
        if (dl) m_data = dv & 16'hFFFF;
        if (pl) m_pc = pv & 12'hFFF;
        check(acc_tag(a, b), int'(acc_out), m_acc);
        check(adr_tag(a, b), int'(adr_out), m_adr);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; mop_a = 0; mop_b = 0; mop_c = 0;
        data_ld = 1'b1; data_in = 16'hFFFF; pc_ld = 1'b1; pc_in = 12'hFFF;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset clears everything; data/pc loads blocked by reset
        check("R1", int'(acc_out), 0);
        check("R1", int'(adr_out), 0);
        m_acc = 0; m_adr = 0; m_data = 0; m_pc = 0;
        rst = 1'b0;
        // R1: data register was cleared, not loaded
        step(5, 0, 0, 0, 0, 0, 0);
        // R6: load and transfer in the same cycle sees the old value
        step(5, 0, 0, 1, 16'hA5C3, 1, 12'h7E1);
        check("R6", int'(adr_out), 0);
        step(5, 0, 0, 0, 0, 0, 0);
        check("R4", int'(adr_out), 12'h5C3);
        step(6, 0, 0, 0, 0, 0, 0);
        check("R5", int'(adr_out), 12'h7E1);
        step(1, 0, 0, 0, 0, 0, 0);
        check("R2", int'(acc_out), 16'hA5C3);
        step(1, 0, 0, 0, 0, 0, 0);
        check("R2", int'(acc_out), 16'h4B86);   // wraps modulo 2^16
        step(0, 3, 0, 1, 16'h0FF0, 0, 0);
        check("R3", int'(acc_out), 16'h0182);
        step(1, 3, 0, 0, 0, 0, 0);
        check("R8", int'(acc_out), 16'h1172);
        step(6, 3, 0, 0, 0, 0, 0);
        check("R9", int'(acc_out), 16'h0170);
        for (int c = 0; c < 8; c++) step(0, 0, c, 0, 0, 0, 0);   // R7 third field
        for (int a = 2; a < 5; a++) step(a, 7, 1, 0, 0, 0, 0);   // R7
        step(7, 2, 7, 0, 0, 0, 0);
        check("R7", int'(acc_out), 16'h0170);
        check("R7", int'(adr_out), 12'h7E1);
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 4095)));
        end
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(acc_out), 0);
        check("R1", int'(adr_out), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule